// File: doc/BRIEF.md
# Neighbour-Shared Local Data Memory

This block is the local data memory of one processing element in a two-dimensional mesh. It has two ports. Port A belongs to the owning element. Port B is shared by two neighbours: the element to the south and the element to the east. Through port B, each element of the mesh can read and write the memories of its north and west neighbours directly, with no block copy over the mesh links.

The shared port has two requesters, so it needs an arbiter. When both neighbours ask in the same cycle, the arbiter grants them in round-robin order. A neighbour that is not granted sees its ready signal low. It holds its request, write flag, address and write data until it is granted. A granted read returns its word one cycle later on a common return bus. The return bus carries a tag naming which neighbour it serves. Port A is never stalled and also reads with one cycle of latency.

The memory defaults to 512 words of 36 bits, which gives 9-bit addresses.

Top module: `nbr_ldm`

## Requirements
- R1: During reset and on the first cycle after it, `nb_rvalid` is low. `s_ready` and `e_ready` are low whenever their request is low.
- R2: At most one of `s_ready` and `e_ready` is high in a cycle. Each is high only when its own request is high. Whenever at least one neighbour requests, one of them is granted in that same cycle.
- R3: When both neighbours request in the same cycle, the first such conflict after reset goes to south. After any grant, the other neighbour is favoured on the next conflict, so under steady contention the grants alternate.
- R4: A granted port-B read (write flag 0) raises `nb_rvalid` on the next cycle. On that cycle `nb_rsel` is 0 for south and 1 for east, and `nb_rdata` holds the addressed word. Without a granted read, `nb_rvalid` is low on the next cycle.
- R5: A port-A read (`own_en`=1, `own_we`=0) presents the addressed word on `own_rdata` on the next cycle. `own_rdata` keeps its value until the next port-A read.
- R6: A word written through either port is returned by a later read through either port. A request that is not granted writes nothing.
- R7: If port A and a granted port-B write hit the same address in the same cycle, the word stored is the port-A data.
- R8: A read in the same cycle as a write to the same address, on either port, returns the contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_en | input | 1 | Port A access enable |
| own_we | input | 1 | Port A write (1) or read (0) |
| own_addr | input | AW | Port A word address |
| own_wdata | input | DW | Port A write data |
| own_rdata | output | DW | Port A read data, one cycle after the read |
| s_req | input | 1 | South neighbour requests port B |
| s_we | input | 1 | South write (1) or read (0) |
| s_addr | input | AW | South word address |
| s_wdata | input | DW | South write data |
| s_ready | output | 1 | South granted this cycle |
| e_req | input | 1 | East neighbour requests port B |
| e_we | input | 1 | East write (1) or read (0) |
| e_addr | input | AW | East word address |
| e_wdata | input | DW | East write data |
| e_ready | output | 1 | East granted this cycle |
| nb_rvalid | output | 1 | Port B read data valid |
| nb_rsel | output | 1 | Port B read owner: 0 south, 1 east |
| nb_rdata | output | DW | Port B read data |

## Verification
The arbiter keeps a single bit of state, the favoured neighbour. If that bit is wrong, the ready pattern is wrong in the very first cycle of the next conflict. The bench checks the ready signals combinationally in every cycle it drives, so such an error shows at once.

A wrong return tag, or a lost or extra read return, shows one cycle after the grant. There the scoreboard finds an unexpected `nb_rvalid`, a missing one, or a mismatched tag or word.

Errors in the write gating show up only when the word is next read. A leaked write from an ungranted requester, or the wrong winner of a same-address collision, appears as a wrong word then. The bench therefore reads each disputed address back in the cycle right after the dispute.

// File: rtl/nbr_ldm.sv
module nbr_ldm #(
  parameter int AW = 9,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          own_en,
  input  logic          own_we,
  input  logic [AW-1:0] own_addr,
  input  logic [DW-1:0] own_wdata,
  output logic [DW-1:0] own_rdata,
  input  logic          s_req,
  input  logic          s_we,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_wdata,
  output logic          s_ready,
  input  logic          e_req,
  input  logic          e_we,
  input  logic [AW-1:0] e_addr,
  input  logic [DW-1:0] e_wdata,
  output logic          e_ready,
  output logic          nb_rvalid,
  output logic          nb_rsel,
  output logic [DW-1:0] nb_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          favor_e;

  wire gnt_s = s_req & (~e_req | ~favor_e);
  wire gnt_e = e_req & (~s_req | favor_e);

  assign s_ready = gnt_s;
  assign e_ready = gnt_e;

  wire          b_go    = gnt_s | gnt_e;
  wire          b_we    = gnt_e ? e_we    : s_we;
  wire [AW-1:0] b_addr  = gnt_e ? e_addr  : s_addr;
  wire [DW-1:0] b_wdata = gnt_e ? e_wdata : s_wdata;

  wire a_wr = own_en & own_we;
  wire a_rd = own_en & ~own_we;
  wire b_wr = b_go & b_we & ~(a_wr && (own_addr == b_addr));
  wire b_rd = b_go & ~b_we;

  always_ff @(posedge clk) begin
    if (a_rd) own_rdata <= mem[own_addr];
    if (b_rd) nb_rdata  <= mem[b_addr];
    if (b_wr) mem[b_addr]   <= b_wdata;
    if (a_wr) mem[own_addr] <= own_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      favor_e   <= 1'b0;
      nb_rvalid <= 1'b0;
      nb_rsel   <= 1'b0;
    end else begin
      if (gnt_s)      favor_e <= 1'b1;
      else if (gnt_e) favor_e <= 1'b0;
      nb_rvalid <= b_rd;
      if (b_rd) nb_rsel <= gnt_e;
    end
  end
endmodule

// File: rtl/nbr_ldm_chk.sv
module nbr_ldm_chk (
  input logic clk,
  input logic rst_n,
  input logic own_en,
  input logic own_we,
  input logic s_req,
  input logic s_we,
  input logic s_ready,
  input logic e_req,
  input logic e_we,
  input logic e_ready,
  input logic nb_rvalid,
  input logic nb_rsel
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && e_ready)); // R2
  AST_READY_OWN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready |-> s_req) and (e_ready |-> e_req)); // R2
  AST_NO_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req || e_req) |-> (s_ready || e_ready)); // R2
  AST_RR_AFTER_S: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(s_ready) && s_req && e_req) |-> e_ready); // R3
  AST_RR_AFTER_E: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(e_ready) && s_req && e_req) |-> s_ready); // R3
  AST_FIRST_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !nb_rvalid); // R1
  AST_S_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_we) |=> (nb_rvalid && !nb_rsel)); // R4
  AST_E_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (e_ready && !e_we) |=> (nb_rvalid && nb_rsel)); // R4
  AST_NO_SPURIOUS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ((!s_ready || s_we) && (!e_ready || e_we)) |=> !nb_rvalid); // R4
endmodule

bind nbr_ldm nbr_ldm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .own_en(own_en), .own_we(own_we),
  .s_req(s_req), .s_we(s_we), .s_ready(s_ready),
  .e_req(e_req), .e_we(e_we), .e_ready(e_ready),
  .nb_rvalid(nb_rvalid), .nb_rsel(nb_rsel)
);

// File: tb/nbr_ldm_bench.sv
module nbr_ldm_bench;
  localparam int AW = 9;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          own_en = 0, own_we = 0, s_req = 0, s_we = 0, e_req = 0, e_we = 0;
  logic [AW-1:0] own_addr = '0, s_addr = '0, e_addr = '0;
  logic [DW-1:0] own_wdata = '0, s_wdata = '0, e_wdata = '0;
  logic [DW-1:0] own_rdata, nb_rdata;
  logic          s_ready, e_ready, nb_rvalid, nb_rsel;

  nbr_ldm #(.AW(AW), .DW(DW)) u_nbr_ldm (
    .clk(clk), .rst_n(rst_n),
    .own_en(own_en), .own_we(own_we), .own_addr(own_addr),
    .own_wdata(own_wdata), .own_rdata(own_rdata),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_ready(s_ready),
    .e_req(e_req), .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata), .e_ready(e_ready),
    .nb_rvalid(nb_rvalid), .nb_rsel(nb_rsel), .nb_rdata(nb_rdata)
  );

  int nchk = 0, nfail = 0;
  bit done = 0, running = 0;
  string tag = "R1";
  logic [DW-1:0] model [1<<AW];
  logic exp_fav_e = 1'b0;
  logic [DW:0]   bq[$];
  logic [DW-1:0] aq[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic ae, input logic aw, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                      input logic sr, input logic sw, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input logic er, input logic ew, input logic [AW-1:0] ea, input logic [DW-1:0] ed,
                      output logic gs, output logic ge);
    logic xs, xe;
    @(negedge clk);
    own_en = ae; own_we = aw; own_addr = aa; own_wdata = ad;
    s_req = sr; s_we = sw; s_addr = sa; s_wdata = sd;
    e_req = er; e_we = ew; e_addr = ea; e_wdata = ed;
    #1;
    xs = sr && (!er || !exp_fav_e);
    xe = er && (!sr || exp_fav_e);
    chk({s_ready, e_ready} == {xs, xe}, (sr && er) ? "R3 grant" : "R2 grant",
        {62'd0, s_ready, e_ready}, {62'd0, xs, xe});
    gs = xs; ge = xe;
    if (ae && !aw) aq.push_back(model[aa]);
    if (xs && !sw) bq.push_back({1'b0, model[sa]});
    if (xe && !ew) bq.push_back({1'b1, model[ea]});
    if (xs && sw && !(ae && aw && aa == sa)) model[sa] = sd;
    if (xe && ew && !(ae && aw && aa == ea)) model[ea] = ed;
    if (ae && aw) model[aa] = ad;
    if (xs) exp_fav_e = 1'b1;
    else if (xe) exp_fav_e = 1'b0;
  endtask

  task automatic idle();
    logic g1, g2;
    step(0,0,0,0, 0,0,0,0, 0,0,0,0, g1, g2);
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (bq.size() != 0) begin
        logic [DW:0] x;
        x = bq.pop_front();
        chk(nb_rvalid && {nb_rsel, nb_rdata} == x, {tag, " / R4 port B return"},
            {26'd0, nb_rvalid, nb_rsel, nb_rdata}, {26'd0, 1'b1, x});
      end else if (nb_rvalid) begin
        chk(1'b0, {tag, " / R4 unexpected return"}, {63'd0, nb_rvalid}, 64'd0);
      end
      if (aq.size() != 0) begin
        logic [DW-1:0] y;
        y = aq.pop_front();
        chk(own_rdata == y, {tag, " / R5 port A return"}, {28'd0, own_rdata}, {28'd0, y});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic gs, ge;
    repeat (3) @(negedge clk);
    chk(nb_rvalid == 1'b0, "R1 rvalid in reset", {63'd0, nb_rvalid}, 64'd0);
    rst_n = 1'b1;
    running = 1;
    idle();
    chk(!s_ready && !e_ready, "R1 ready idle", {62'd0, s_ready, e_ready}, 64'd0);

    tag = "R3";
    step(0,0,0,0, 1,1,9'd20,36'h0000000A1, 1,1,9'd21,36'h0000000B2, gs, ge);
    chk(gs && !ge && s_ready, "R3 south first after reset", {63'd0, s_ready}, 64'd1);
    step(0,0,0,0, 0,0,0,0, 1,1,9'd21,36'h0000000B2, gs, ge);
    step(1,0,9'd20,0, 0,0,0,0, 0,0,0,0, gs, ge);
    step(1,0,9'd21,0, 0,0,0,0, 0,0,0,0, gs, ge);
    for (int i = 0; i < 6; i++)
      step(0,0,0,0, 1,0,9'd20,0, 1,0,9'd21,0, gs, ge);
    idle();

    tag = "R5";
    step(1,1,9'd5,36'h123456789, 0,0,0,0, 0,0,0,0, gs, ge);
    step(1,0,9'd5,0, 0,0,0,0, 0,0,0,0, gs, ge);
    idle(); idle();
    chk(own_rdata == 36'h123456789, "R5 own_rdata holds", {28'd0, own_rdata}, 64'h123456789);

    tag = "R6";
    step(0,0,0,0, 1,1,9'd10,36'hABCDE0001, 0,0,0,0, gs, ge);
    step(1,0,9'd10,0, 0,0,0,0, 1,1,9'd11,36'h5A5A5A5A5, gs, ge);
    step(0,0,0,0, 1,0,9'd11,0, 0,0,0,0, gs, ge);
    step(0,0,0,0, 0,0,0,0, 1,0,9'd10,0, gs, ge);
    step(1,1,9'd51,36'h000000011, 0,0,0,0, 0,0,0,0, gs, ge);
    do step(0,0,0,0, 1,1,9'd50,36'h0000000F0, 1,1,9'd51,36'hFFFFFFFFF, gs, ge);
    while (!gs);
    step(1,0,9'd51,0, 0,0,0,0, 1,1,9'd51,36'hFFFFFFFFF, gs, ge);
    step(1,0,9'd51,0, 0,0,0,0, 0,0,0,0, gs, ge);

    tag = "R7";
    step(1,1,9'd30,36'hAAAAAAAAA, 1,1,9'd30,36'h555555555, 0,0,0,0, gs, ge);
    step(1,0,9'd30,0, 0,0,0,0, 0,0,0,0, gs, ge);
    step(1,1,9'd31,36'h00000C0DE, 0,0,0,0, 1,1,9'd30,36'h0000BEEF0, gs, ge);
    step(1,0,9'd31,0, 0,0,0,0, 1,0,9'd30,0, gs, ge);
    step(1,1,9'd32,36'h777777777, 0,0,0,0, 1,1,9'd32,36'h111111111, gs, ge);
    step(0,0,0,0, 1,0,9'd32,0, 0,0,0,0, gs, ge);
    chk(1'b1, "R7 collision sequence issued", 64'd0, 64'd0);

    tag = "R8";
    step(1,1,9'd40,36'h0000000C1, 1,1,9'd41,36'h0000000D1, 0,0,0,0, gs, ge);
    step(1,1,9'd40,36'h0000000C2, 0,0,0,0, 1,0,9'd40,0, gs, ge);
    step(1,0,9'd41,0, 1,1,9'd41,36'h0000000D2, 0,0,0,0, gs, ge);
    step(1,0,9'd41,0, 0,0,0,0, 1,0,9'd40,0, gs, ge);

    tag = "R2";
    for (int i = 0; i < 4; i++)
      step(0,0,0,0, 0,0,0,0, 1,0,AW'(20 + (i % 2)),0, gs, ge);
    for (int i = 0; i < 3; i++)
      step(0,0,0,0, 1,0,9'd5,0, 0,0,0,0, gs, ge);
    idle(); idle(); idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule